// File: doc/BRIEF.md
# Packed SIMD Element Width Converter

This unit changes the element width of packed data carried in two 64-bit operands. In its interleave direction it takes elements from the same half (both low or both high) of the two operands and alternates them, so each pair in the result is one element twice as wide. Interleaving with an all-zero second operand is the usual way to zero-extend bytes to 16 bits. In its narrowing direction it cuts every element of both operands to half its width and joins the two narrowed groups into one 64-bit word. Narrowing can clamp with a signed range, clamp with an unsigned range, or simply drop the upper half.

Each accepted operation produces a registered result one clock later, flagged by a one-cycle valid pulse. A two-state output machine tracks this. ST_IDLE moves to ST_OUT when the valid strobe is high (transition T_ACCEPT). ST_OUT stays in ST_OUT on a new strobe (T_CHAIN) or returns to ST_IDLE without one (T_DRAIN). ST_IDLE stays in ST_IDLE without a strobe (T_WAIT).

Top module: `simd_width_conv`

## Requirements
- R1: With in_op = 0 (interleave low), for element width 8 (in_wide = 0) or 16 (in_wide = 1), element i of the low 32 bits of in_a goes to result element 2i and element i of the low 32 bits of in_b goes to result element 2i+1.
- R2: With in_op = 1 (interleave high), R1 applies to the high 32 bits of both operands.
- R3: Interleave low at byte width with in_b = 0 gives each 16-bit result lane equal to the zero-extended byte i of in_a.
- R4: With in_op = 2 (narrow, signed clamp), each signed source element (16 bits if in_wide = 0, 32 bits if in_wide = 1) is clamped to the most negative to most positive range of half its width. The narrowed elements of in_a fill the low 32 bits of the result in order, and those of in_b fill the high 32 bits.
- R5: With in_op = 3 (narrow, unsigned clamp), each source element is read as signed and clamped to the range 0 to all-ones of half its width. The placement is as in R4.
- R6: With in_op = 4 (narrow, modulo), each element keeps only its lower half. The placement is as in R4.
- R7: When in_valid is high at a clock edge, out_valid is high after that edge and out_result holds the result of the inputs sampled there.
- R8: When in_valid is low at a clock edge, out_valid is low after it and out_result keeps its previous value.
- R9: After reset, out_valid is 0 and out_result is 0.
- R10: Opcodes 5 to 7 give a result of 0, accompanied by out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code (0 to 4 used) |
| in_wide | input | 1 | Element size select: 0 = byte interleave / 16-to-8 narrow, 1 = word interleave / 32-to-16 narrow |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 64 | Registered result |

## Verification
The properties assume that in_op, in_wide and both operands are stable and known whenever in_valid is high. They also assume nothing else drives the result between strobes. The bench changes inputs only on the falling edge, so each set of inputs is settled before the rising edge that samples it. Opcodes 5 to 7 are driven on purpose to exercise R10. The bench mixes strobed and idle cycles to cover the T_ACCEPT, T_CHAIN, T_DRAIN and T_WAIT transitions.

// File: rtl/simd_conv_pkg.sv
package simd_conv_pkg;
    typedef enum logic [2:0] {
        OP_ILV_LO  = 3'd0,
        OP_ILV_HI  = 3'd1,
        OP_NAR_SS  = 3'd2,
        OP_NAR_US  = 3'd3,
        OP_NAR_MOD = 3'd4
    } conv_op_t;

    typedef enum logic [1:0] {
        NM_SIGNED   = 2'd0,
        NM_UNSIGNED = 2'd1,
        NM_MODULO   = 2'd2
    } narrow_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } out_state_t;
endpackage

// File: rtl/simd_interleave.sv
module simd_interleave #(
    parameter int DW = 64,
    parameter int EW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          use_hi,
    output logic [DW-1:0] y
);
    localparam int HALF  = DW / 2;
    localparam int PAIRS = HALF / EW;

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign y[(2*i)*EW   +: EW] = use_hi ? a[HALF + i*EW +: EW] : a[i*EW +: EW];
        assign y[(2*i+1)*EW +: EW] = use_hi ? b[HALF + i*EW +: EW] : b[i*EW +: EW];
    end
endmodule

// File: rtl/simd_narrow.sv
module simd_narrow
    import simd_conv_pkg::*;
#(
    parameter int DW = 64,
    parameter int SW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  narrow_mode_t  mode,
    output logic [DW-1:0] y
);
    localparam int NW    = SW / 2;
    localparam int LANES = DW / SW;

    for (genvar g = 0; g < 2*LANES; g++) begin : g_lane
        logic [SW-1:0] src;
        logic [NW-1:0] res;
        logic          fits_s;
        logic          fits_u;

        if (g < LANES) begin : g_from_a
            assign src = a[g*SW +: SW];
        end else begin : g_from_b
            assign src = b[(g-LANES)*SW +: SW];
        end

        assign fits_s = (src[SW-1:NW-1] == '0) || (src[SW-1:NW-1] == '1);
        assign fits_u = (src[SW-1:NW] == '0);

        always_comb begin
            unique case (mode)
                NM_SIGNED: begin
                    if (fits_s)          res = src[NW-1:0];
                    else if (src[SW-1])  res = {1'b1, {(NW-1){1'b0}}};
                    else                 res = {1'b0, {(NW-1){1'b1}}};
                end
                NM_UNSIGNED: begin
                    if (src[SW-1])       res = '0;
                    else if (!fits_u)    res = '1;
                    else                 res = src[NW-1:0];
                end
                default:                 res = src[NW-1:0];
            endcase
        end

        // R4: a non-negative source never becomes negative under signed clamp
        always_comb begin
            if (mode == NM_SIGNED && src[SW-1] == 1'b0) begin
                assert_sat_sign_R4: assert (res[NW-1] == 1'b0);
            end
        end

        assign y[g*NW +: NW] = res;
    end
endmodule

// File: rtl/simd_width_conv.sv
module simd_width_conv
    import simd_conv_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic          in_wide,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic          out_valid,
    output logic [DW-1:0] out_result
);
    localparam int EW_S = 8;
    localparam int EW_W = 16;

    conv_op_t     op;
    narrow_mode_t nmode;
    out_state_t   st_q, st_d;
    logic [DW-1:0] ilv_s, ilv_w, nar_s, nar_w, res_d, res_q;

    assign op = conv_op_t'(in_op);

    always_comb begin
        unique case (op)
            OP_NAR_US: nmode = NM_UNSIGNED;
            OP_NAR_MOD: nmode = NM_MODULO;
            default:   nmode = NM_SIGNED;
        endcase
    end

    simd_interleave #(.DW(DW), .EW(EW_S)) u_ilv_s (
        .a(in_a), .b(in_b), .use_hi(op == OP_ILV_HI), .y(ilv_s));
    simd_interleave #(.DW(DW), .EW(EW_W)) u_ilv_w (
        .a(in_a), .b(in_b), .use_hi(op == OP_ILV_HI), .y(ilv_w));
    simd_narrow #(.DW(DW), .SW(2*EW_S)) u_nar_s (
        .a(in_a), .b(in_b), .mode(nmode), .y(nar_s));
    simd_narrow #(.DW(DW), .SW(2*EW_W)) u_nar_w (
        .a(in_a), .b(in_b), .mode(nmode), .y(nar_w));

    always_comb begin
        unique case (op)
            OP_ILV_LO, OP_ILV_HI:            res_d = in_wide ? ilv_w : ilv_s;
            OP_NAR_SS, OP_NAR_US, OP_NAR_MOD: res_d = in_wide ? nar_w : nar_s;
            default:                          res_d = '0;
        endcase
    end

    // next-state: T_ACCEPT / T_CHAIN on strobe, T_DRAIN / T_WAIT without
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  st_d = in_valid ? ST_OUT : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= res_d;
    end

    assign out_valid  = (st_q == ST_OUT);
    assign out_result = res_q;

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
    assert_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd0 && !in_wide && in_b == '0)
        |=> (((out_result & 64'hFF00_FF00_FF00_FF00) == '0)
             && out_result[7:0] == $past(in_a[7:0])));
endmodule

// File: tb/sim_simd_width_conv.sv
`timescale 1ns/1ps
module sim_simd_width_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_wide = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [63:0] exp_res = '0;

    always #2 clk = ~clk;

    simd_width_conv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result));

    function automatic logic [63:0] model(int op, bit wide, logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        if (op == 0 || op == 1) begin
            int ew = wide ? 16 : 8;
            int base = (op == 1) ? 32 : 0;
            longint m = (64'sd1 <<< ew) - 1;
            for (int i = 0; i < 32/ew; i++) begin
                r = r | (((a >> (base + i*ew)) & m) << (2*i*ew));
                r = r | (((b >> (base + i*ew)) & m) << ((2*i+1)*ew));
            end
        end else if (op >= 2 && op <= 4) begin
            int sw = wide ? 32 : 16;
            int nw = sw / 2;
            int n  = 64 / sw;
            longint smask = (64'sd1 <<< sw) - 1;
            longint nmask = (64'sd1 <<< nw) - 1;
            longint maxs  = (64'sd1 <<< (nw-1)) - 1;
            longint mins  = -(64'sd1 <<< (nw-1));
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < n; i++) begin
                    longint x = longint'(((s == 0 ? a : b) >> (i*sw)) & smask);
                    longint v;
                    if (x >= (64'sd1 <<< (sw-1))) x = x - (64'sd1 <<< sw);
                    if (op == 2)      v = (x > maxs) ? maxs : ((x < mins) ? mins : x);
                    else if (op == 3) v = (x < 0) ? 0 : ((x > nmask) ? nmask : x);
                    else              v = x;
                    r = r | (64'(v & nmask) << ((s*n + i)*nw));
                end
            end
        end
        return r;
    endfunction

    function automatic string tag_of(bit v, int op, logic [63:0] b, bit wide);
        if (!v) return "R8";
        case (op)
            0: return (b == 0 && !wide) ? "R3" : "R1";
            1: return "R2";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic step(bit v, int op, bit wide, logic [63:0] a, logic [63:0] b);
        string t = tag_of(v, op, b, wide);
        in_valid = v; in_op = 3'(op); in_wide = wide; in_a = a; in_b = b;
        @(negedge clk);
        if (v) exp_res = model(op, wide, a, b);
        n_tests++;
        if (out_valid !== v || out_result !== exp_res) begin
            n_fail++;
            $display("FAIL %s/R7: valid=%0b result=%h expected valid=%0b result=%h",
                     t, out_valid, out_result, v, exp_res);
        end
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || out_result !== '0) begin
            n_fail++;
            $display("FAIL R9: valid=%0b result=%h expected valid=0 result=0", out_valid, out_result);
        end
        rst_n = 1'b1;
        @(negedge clk);
        step(0, 0, 0, 64'h1, 64'h2);
        step(1, 0, 0, 64'h0706050403020100, 64'hF7F6F5F4F3F2F1F0);
        step(1, 0, 1, 64'h0706050403020100, 64'hF7F6F5F4F3F2F1F0);
        step(1, 1, 0, 64'h0706050403020100, 64'hF7F6F5F4F3F2F1F0);
        step(1, 1, 1, 64'h0706050403020100, 64'hF7F6F5F4F3F2F1F0);
        step(1, 0, 0, 64'h8899AABBCCDDEEFF, 64'h0);
        step(1, 2, 0, 64'h7FFF_8000_0080_FF7F, 64'h007F_FF80_0000_FFFF);
        step(1, 2, 1, 64'h0000_8000_FFFF_7FFF, 64'h8000_0000_0000_7FFF);
        step(1, 3, 0, 64'h7FFF_8000_00FF_0100, 64'hFFFF_0000_0080_00FE);
        step(1, 3, 1, 64'h0001_0000_FFFF_FFFF, 64'h0000_FFFF_0000_FFFE);
        step(1, 4, 0, 64'h1234_5678_9ABC_DEF0, 64'hFFEE_DDCC_BBAA_9988);
        step(1, 4, 1, 64'h1234_5678_9ABC_DEF0, 64'hFFEE_DDCC_BBAA_9988);
        step(0, 2, 0, 64'h7FFF_7FFF_7FFF_7FFF, 64'h0);
        step(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        step(1, 5, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        step(1, 7, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        step(0, 1, 0, 64'h0, 64'h0);
        for (int k = 0; k < 600; k++) begin
            bit v = ($urandom_range(0, 3) != 0);
            int op = $urandom_range(0, 7);
            logic [63:0] a = {$urandom(), $urandom()};
            logic [63:0] b = ($urandom_range(0, 7) == 0) ? 64'h0 : {$urandom(), $urandom()};
            step(v, op, 1'($urandom_range(0, 1)), a, b);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule